// File: doc/BRIEF.md
# Interlocked Glitch-Free Base Clock Selector

This block picks the source of a chip's base clock: either the free-running oscillator clock or the divided PLL clock. A change of source is carried out as a handshake between the two clock domains. The outgoing source is gated off while its clock is low, and only then is the incoming source gated on while its own clock is low. The output stays still while this happens. The gated clock is then divided by two, which gives a base clock with a 50% duty cycle. The base clock is divided by two again to give the bus clock.

Software controls the block through a single write port. The port carries two control bits: the PLL enable and the PLL source select. The port only accepts a combination that keeps the PLL clock trustworthy. The PLL clock cannot be selected unless the PLL is on, and the PLL cannot be turned off while its clock is selected. A single write may not change both bits at once. If the VCO range factor is zero, the PLL is treated as off and the oscillator is forced as the source. A zero in either the reference divider field or the feedback divider field is passed on as one.

Top module: `clk_src_sel`

## Requirements
- R1: While `rst_n` is low, `pll_on`, `pll_sel`, `src_is_pll`, `base_clk` and `bus_clk` are all 0, so the oscillator is the selected source.
- R2: `base_clk` toggles on each rising edge of the active source, so its period is twice the source period. `bus_clk` toggles on each rising edge of `base_clk`, so its period is four times the source period.
- R3: A source change holds `base_clk` still while the handover runs. No high or low phase of `base_clk` is ever shorter than one period of the faster source.
- R4: `src_is_pll` (1 = PLL clock driving the output) changes only after the handover completes. The handover completes within three periods of the oscillator clock plus three periods of the PLL clock, counted from the accepting write or from the change of the range factor.
- R5: A write that sets the select bit is refused while `pll_on` is 0.
- R6: A write that clears `pll_on` is refused while `pll_sel` is 1.
- R7: A write whose `wr_pll_on` and `wr_use_pll` values both differ from the current `pll_on` and `pll_sel` is refused as a whole.
- R8: When `range_l` is zero, a write that sets the select bit is refused. If the range factor becomes zero while the PLL is selected, the output falls back to the oscillator.
- R9: `ref_div_eff` and `fb_div_eff` equal their input fields, except that an input of zero gives one.
- R10: A write allowed by R5 to R8 updates `pll_on` and `pll_sel` on the `reg_clk` edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Clock for the control write port |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_clk | input | 1 | Oscillator clock |
| pll_clk | input | 1 | Divided PLL clock |
| wr_en | input | 1 | Control write strobe |
| wr_pll_on | input | 1 | New PLL enable value |
| wr_use_pll | input | 1 | New source select value (1 = PLL) |
| range_l | input | LW | VCO range factor; zero disables the PLL |
| ref_div | input | DW | Reference divider field |
| fb_div | input | DW | Feedback divider field |
| pll_on | output | 1 | Current PLL enable |
| pll_sel | output | 1 | Current source select bit |
| src_is_pll | output | 1 | Source now driving the output (1 = PLL) |
| ref_div_eff | output | DW | Reference divider with zero read as one |
| fb_div_eff | output | DW | Feedback divider with zero read as one |
| base_clk | output | 1 | Selected source divided by two |
| bus_clk | output | 1 | Base clock divided by two |

## Verification
The bench builds the block with its default parameters: a 3-bit range factor, 12-bit divider fields and two synchronizer stages. The 3-bit range factor is narrow enough to drive the zero case of R8 directly. The default depth gives the handover bound stated in R4. The oscillator runs at 40 ns and the PLL at 12 ns. These rates are unrelated, so each handover crosses between two non-harmonic domains, and a glitch would show up as a base-clock phase shorter than 12 ns.

// File: rtl/clk_src_sel.sv
module clk_src_sel #(
  parameter int LW   = 3,
  parameter int DW   = 12,
  parameter int SYNC = 2
) (
  input  logic          reg_clk,
  input  logic          rst_n,
  input  logic          osc_clk,
  input  logic          pll_clk,
  input  logic          wr_en,
  input  logic          wr_pll_on,
  input  logic          wr_use_pll,
  input  logic [LW-1:0] range_l,
  input  logic [DW-1:0] ref_div,
  input  logic [DW-1:0] fb_div,
  output logic          pll_on,
  output logic          pll_sel,
  output logic          src_is_pll,
  output logic [DW-1:0] ref_div_eff,
  output logic [DW-1:0] fb_div_eff,
  output logic          base_clk,
  output logic          bus_clk
);

  logic on_q, sel_q, src_q;
  logic l_zero, chg_on, chg_sel, refuse;
  logic want_pll, osc_req, pll_req, osc_gate, pll_gate, mux_clk;
  logic base_q, bus_q;
  logic [SYNC-1:0] osc_sync, pll_sync;

  assign ref_div_eff = (ref_div == '0) ? DW'(1) : ref_div;
  assign fb_div_eff  = (fb_div  == '0) ? DW'(1) : fb_div;

  assign l_zero  = (range_l == '0);
  assign chg_on  = (wr_pll_on  != on_q);
  assign chg_sel = (wr_use_pll != sel_q);
  assign refuse  = (chg_on && chg_sel)
                || (chg_sel && wr_use_pll && (!on_q || l_zero))
                || (chg_on && !wr_pll_on && sel_q);

  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (wr_en && !refuse) begin
      on_q  <= wr_pll_on;
      sel_q <= wr_use_pll;
    end
  end

  assign want_pll = sel_q && on_q && !l_zero;
  assign osc_req  = !want_pll && !pll_gate;
  assign pll_req  = want_pll && !osc_gate;

  always_ff @(negedge osc_clk or negedge rst_n) begin
    if (!rst_n) osc_sync <= '1;
    else        osc_sync <= {osc_sync[SYNC-2:0], osc_req};
  end

  always_ff @(negedge pll_clk or negedge rst_n) begin
    if (!rst_n) pll_sync <= '0;
    else        pll_sync <= {pll_sync[SYNC-2:0], pll_req};
  end

  assign osc_gate = osc_sync[SYNC-1];
  assign pll_gate = pll_sync[SYNC-1];
  assign mux_clk  = (osc_clk && osc_gate) || (pll_clk && pll_gate);

  always_ff @(posedge reg_clk or negedge rst_n) begin
    if (!rst_n)        src_q <= 1'b0;
    else if (pll_gate) src_q <= 1'b1;
    else if (osc_gate) src_q <= 1'b0;
  end

  always_ff @(posedge mux_clk or negedge rst_n) begin
    if (!rst_n) base_q <= 1'b0;
    else        base_q <= ~base_q;
  end

  always_ff @(posedge base_q or negedge rst_n) begin
    if (!rst_n) bus_q <= 1'b0;
    else        bus_q <= ~bus_q;
  end

  assign pll_on     = on_q;
  assign pll_sel    = sel_q;
  assign src_is_pll = src_q;
  assign base_clk   = base_q;
  assign bus_clk    = bus_q;

  p_gates_exclusive_r3: assert property (@(posedge reg_clk) disable iff (!rst_n)
    !(osc_gate && pll_gate));

  p_sel_needs_on_r5: assert property (@(posedge reg_clk) disable iff (!rst_n)
    sel_q |-> on_q);

  p_single_change_r7: assert property (@(posedge reg_clk) disable iff (!rst_n)
    !(!$stable(on_q) && !$stable(sel_q)));

  p_zero_range_blocks_r8: assert property (@(posedge reg_clk) disable iff (!rst_n)
    (wr_en && wr_use_pll && !sel_q && l_zero) |=> !sel_q);

  p_status_after_handover_r4: assert property (@(posedge reg_clk) disable iff (!rst_n)
    $rose(src_q) |-> !osc_gate);

endmodule

// File: tb/clk_src_sel_bench.sv
`timescale 1ns/1ps
module clk_src_sel_bench;
  localparam int LW = 3;
  localparam int DW = 12;
  localparam real OSC_P = 40.0;
  localparam real PLL_P = 12.0;

  logic reg_clk = 0, osc_clk = 0, pll_clk = 0, rst_n = 0;
  logic wr_en = 0, wr_pll_on = 0, wr_use_pll = 0;
  logic [LW-1:0] range_l = 3'd3;
  logic [DW-1:0] ref_div = '0, fb_div = '0;
  logic pll_on, pll_sel, src_is_pll, base_clk, bus_clk;
  logic [DW-1:0] ref_div_eff, fb_div_eff;

  int checks = 0, failures = 0, glitches = 0;
  bit done = 0;

  typedef struct { logic on; logic sel; string req; } exp_t;
  exp_t exp_q[$];

  always #2.5 reg_clk = ~reg_clk;
  always #(OSC_P/2) osc_clk = ~osc_clk;
  always #(PLL_P/2) pll_clk = ~pll_clk;

  clk_src_sel #(.LW(LW), .DW(DW)) u_clk_src_sel (
    .reg_clk, .rst_n, .osc_clk, .pll_clk, .wr_en, .wr_pll_on, .wr_use_pll,
    .range_l, .ref_div, .fb_div, .pll_on, .pll_sel, .src_is_pll,
    .ref_div_eff, .fb_div_eff, .base_clk, .bus_clk);

  task automatic check(input bit ok, input string req, input string what,
                       input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  always @(negedge reg_clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(pll_on == e.on, e.req, "pll_on", real'(pll_on), real'(e.on));
      check(pll_sel == e.sel, e.req, "pll_sel", real'(pll_sel), real'(e.sel));
    end
  end

  real last_b;
  bit seen_b = 0;
  always @(base_clk) begin
    if (rst_n) begin
      if (seen_b && ($realtime - last_b) < PLL_P - 0.5) glitches++;
      last_b = $realtime;
      seen_b = 1;
    end
  end

  task automatic wr(input logic on, input logic sel, input logic eon,
                    input logic esel, input string req);
    exp_t e;
    @(negedge reg_clk);
    wr_en = 1; wr_pll_on = on; wr_use_pll = sel;
    @(posedge reg_clk);
    #1;
    e.on = eon; e.sel = esel; e.req = req;
    exp_q.push_back(e);
    @(negedge reg_clk);
    wr_en = 0;
    #0.1;
  endtask

  task automatic periods(input real src_p, input string req);
    real t1, t2;
    @(posedge base_clk); @(posedge base_clk); t1 = $realtime;
    @(posedge base_clk); t2 = $realtime;
    check((t2 - t1) > 2*src_p - 0.1 && (t2 - t1) < 2*src_p + 0.1, req,
          "base period", t2 - t1, 2*src_p);
    @(posedge bus_clk); t1 = $realtime;
    @(posedge bus_clk); t2 = $realtime;
    check((t2 - t1) > 4*src_p - 0.1 && (t2 - t1) < 4*src_p + 0.1, req,
          "bus period", t2 - t1, 4*src_p);
  endtask

  task automatic wait_src(input logic v, input real t0, input string req);
    real el;
    for (int i = 0; i < 400 && src_is_pll !== v; i++) #1;
    el = $realtime - t0;
    check(src_is_pll === v, req, "src_is_pll", real'(src_is_pll), real'(v));
    check(el <= 3*OSC_P + 3*PLL_P + 5.0, req, "handover ns", el, 3*OSC_P + 3*PLL_P);
  endtask

  initial begin
    real t0;
    #23;
    check(pll_on === 0 && pll_sel === 0, "R1", "ctrl at reset", real'(pll_on), 0);
    check(src_is_pll === 0, "R1", "status at reset", real'(src_is_pll), 0);
    check(base_clk === 0 && bus_clk === 0, "R1", "clocks at reset", real'(base_clk), 0);
    rst_n = 1;

    periods(OSC_P, "R2");

    ref_div = 0; fb_div = 12'd5; #1;
    check(ref_div_eff == 1, "R9", "ref zero", real'(ref_div_eff), 1);
    check(fb_div_eff == 5, "R9", "fb nonzero", real'(fb_div_eff), 5);
    ref_div = 12'd7; fb_div = 0; #1;
    check(ref_div_eff == 7, "R9", "ref nonzero", real'(ref_div_eff), 7);
    check(fb_div_eff == 1, "R9", "fb zero", real'(fb_div_eff), 1);

    wr(0, 1, 0, 0, "R5");
    wr(1, 1, 0, 0, "R7");
    wr(1, 0, 1, 0, "R10");
    range_l = 0;
    wr(1, 1, 1, 0, "R8");
    range_l = 3'd3;

    wr(1, 1, 1, 1, "R10");
    t0 = $realtime - 3.6;
    check(src_is_pll === 0, "R4", "status before handover", real'(src_is_pll), 0);
    wait_src(1, t0, "R4");
    periods(PLL_P, "R2");

    wr(0, 1, 1, 1, "R6");
    wr(0, 0, 1, 1, "R7");

    t0 = $realtime;
    range_l = 0;
    wait_src(0, t0, "R8");
    periods(OSC_P, "R8");
    range_l = 3'd3;
    wait_src(1, $realtime, "R4");

    wr(1, 0, 1, 0, "R10");
    t0 = $realtime - 3.6;
    wait_src(0, t0, "R4");
    periods(OSC_P, "R2");
    wr(0, 0, 0, 0, "R10");

    repeat (4) @(negedge reg_clk);
    check(glitches == 0, "R3", "short base phases", real'(glitches), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #500us;
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule